// File: doc/BRIEF.md
# Two-Level Raster Dot Capture

This block sits on the input side of a display converter. It receives a monochrome raster whose picture is carried on two digital lines: one says that a dot is being drawn, the other says whether that dot is bright or dim. It samples these lines on the incoming dot clock. It rebuilds the horizontal and vertical position from the two sync inputs. It then writes every dot that falls inside a programmable active window into an on-chip dual-port buffer as a 2-bit code.

The source raster is nonstandard. A line is 1352 dot clocks long with a 96-clock horizontal sync, and a frame is 312 lines long with a 3-line vertical sync. The picture area is 512 dots by 254 lines. Where that area begins inside the line and inside the frame moves with the picture position controls. For this reason both window start offsets are inputs. They are sampled once per frame. The readout side gets a single-cycle pulse when the first dot of a new frame lands in the buffer.

Top module: `dotline_capture`

## Requirements
- R1: Both sync inputs pass through a two-flop synchronizer. The pixel index of a sample is the number of dot clocks since the sample in which horizontal sync was first seen high, so that sample has index 0. A sync held high for many clocks counts as a single leading edge.
- R2: The line index is the number of horizontal sync leading edges since the last vertical sync leading edge. The line in which vertical sync rises is line 0. When both leading edges arrive in the same sample, the line index becomes 0 and is not incremented.
- R3: A buffer write happens only for a sample whose pixel index lies in [hs, hs+ACT_W) and whose line index lies in [vs, vs+ACT_H). Here hs and vs are the offsets in force for that frame. Each such sample is written exactly once.
- R4: The write address is (line index − vs) × ACT_W + (pixel index − hs), and it is always below ACT_W × ACT_H.
- R5: The write data bit 1 is the dot-lit input and bit 0 is the bright input, both taken from the same sample.
- R6: The offsets `h_start` and `v_start` are sampled at each vertical sync leading edge. A change made in the middle of a frame has no effect until the next vertical sync leading edge.
- R7: `frame_start` is high for exactly the cycle in which address 0 is written, and at no other time. A frame whose relative origin dot is not captured produces no pulse.
- R8: After reset, and until sync leading edges arrive, no write occurs and `frame_start` stays low. Without a horizontal sync the pixel counter holds at its maximum instead of wrapping back into the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Vertical sync, active high |
| dot_in | input | 1 | High while a dot is drawn |
| bright_in | input | 1 | High for a bright dot, low for a dim one |
| h_start | input | PIX_W (11) | First active pixel index of the window |
| v_start | input | LINE_W (9) | First active line index of the window |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W (17) | Buffer write address |
| wr_data | output | 2 | Stored code {lit, bright} |
| frame_start | output | 1 | Pulse with the write of address 0 |

## Verification
Two events can fall in the same sample: a vertical sync leading edge and a horizontal sync leading edge. The first would reset the line index and the second would advance it. The directed frames raise both syncs in one sample, and a separate frame raises vertical sync partway through a line. A per-sample model in the bench predicts every captured dot for each case. It judges the outcome by whether every buffer word, the write count and the frame pulse count match that prediction. The other coincidence is an offset change landing during a frame that is already being captured. It is provoked by rewriting both offsets mid-frame and then confirming that the whole frame still lands at the old window.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  // Stored code of one captured dot.
  typedef struct packed {
    logic lit;
    logic bright;
  } dot_code_t;

  // True when pos lies in the half-open span [start, start+len).
  function automatic logic in_span(input int unsigned pos,
                                   input int unsigned start,
                                   input int unsigned len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // Row-major linear buffer address.
  function automatic int unsigned lin_addr(input int unsigned row,
                                           input int unsigned col,
                                           input int unsigned width);
    return row * width + col;
  endfunction

endpackage

// File: rtl/dlc_sync_edge.sv
module dlc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lead
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  // Leading edge as seen after the synchronizer stages.
  assign lead = sh[STAGES-1] & ~sh[STAGES];

  // A held pulse gives one edge only.
  p_lead_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> !lead);

endmodule

// File: rtl/dlc_pipe.sv
module dlc_pipe #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] st [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign dout = st[DEPTH-1];

endmodule

// File: rtl/dlc_raster.sv
module dlc_raster #(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_lead,
  input  logic              v_lead,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line
);

  localparam logic [PIX_W-1:0]  PIX_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix  <= PIX_MAX;
      line <= LINE_MAX;
    end else begin
      if (h_lead)              pix <= '0;
      else if (pix != PIX_MAX) pix <= pix + 1'b1;

      if (v_lead)                            line <= '0;
      else if (h_lead && line != LINE_MAX)   line <= line + 1'b1;
    end
  end

  p_pix_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    h_lead |=> (pix == '0));

  p_line_vwins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_lead |=> (line == '0));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_lead && !v_lead && line != LINE_MAX) |=> (line == $past(line) + 1'b1));

  p_line_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_lead && !v_lead) |=> $stable(line));

  p_pix_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_lead && pix == PIX_MAX) |=> (pix == PIX_MAX));

endmodule

// File: rtl/dlc_window.sv
module dlc_window
  import dlc_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 9,
  parameter int ACT_W  = 512,
  parameter int ACT_H  = 254,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic              v_lead,
  input  dot_code_t         code,
  input  logic [PIX_W-1:0]  h_start,
  input  logic [LINE_W-1:0] v_start,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_data,
  output logic              frame_start
);

  logic [PIX_W-1:0]  hs_q;
  logic [LINE_W-1:0] vs_q;
  logic              x_hit, y_hit, win_hit, origin_hit;
  logic [PIX_W-1:0]  rel_x;
  logic [LINE_W-1:0] rel_y;
  logic [ADDR_W-1:0] addr_nx;

  always_comb begin
    x_hit      = in_span(32'(pix),  32'(hs_q), ACT_W);
    y_hit      = in_span(32'(line), 32'(vs_q), ACT_H);
    win_hit    = x_hit && y_hit;
    rel_x      = pix - hs_q;
    rel_y      = line - vs_q;
    addr_nx    = ADDR_W'(lin_addr(32'(rel_y), 32'(rel_x), ACT_W));
    origin_hit = win_hit && (rel_x == '0) && (rel_y == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q        <= '0;
      vs_q        <= '0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      frame_start <= 1'b0;
    end else begin
      if (v_lead) begin
        hs_q <= h_start;
        vs_q <= v_start;
      end
      wr_en       <= win_hit;
      wr_addr     <= addr_nx;
      wr_data     <= code;
      frame_start <= origin_hit;
    end
  end

  p_fs_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (wr_en && wr_addr == '0));

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < ACT_W * ACT_H));

  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !v_lead |=> ($stable(hs_q) && $stable(vs_q)));

endmodule

// File: rtl/dotline_capture.sv
module dotline_capture
  import dlc_pkg::*;
#(
  parameter int PIX_W       = 11,
  parameter int LINE_W      = 9,
  parameter int ACT_W       = 512,
  parameter int ACT_H       = 254,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(ACT_W * ACT_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              dot_in,
  input  logic              bright_in,
  input  logic [PIX_W-1:0]  h_start,
  input  logic [LINE_W-1:0] v_start,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_data,
  output logic              frame_start
);

  // Video is delayed one stage past the sync path so that the sample in
  // which horizontal sync first appears lines up with pixel index 0.
  localparam int VID_DEPTH = SYNC_STAGES + 1;
  localparam int N_SYNC    = 2;
  localparam int IDX_H     = 0;
  localparam int IDX_V     = 1;

  logic [N_SYNC-1:0] sync_raw;
  logic [N_SYNC-1:0] sync_lead;
  logic              h_lead;
  logic              v_lead;
  logic [1:0]        vid_raw;
  logic [1:0]        vid_dly;
  dot_code_t         code_al;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;

  assign sync_raw[IDX_H] = hsync_in;
  assign sync_raw[IDX_V] = vsync_in;

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    dlc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sync_raw[g]),
      .lead (sync_lead[g])
    );
  end

  assign h_lead = sync_lead[IDX_H];
  assign v_lead = sync_lead[IDX_V];

  assign vid_raw = {dot_in, bright_in};

  dlc_pipe #(.WIDTH(2), .DEPTH(VID_DEPTH)) u_vid (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (vid_raw),
    .dout (vid_dly)
  );

  assign code_al = dot_code_t'(vid_dly);

  dlc_raster #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_raster (
    .clk   (clk),
    .rst_n (rst_n),
    .h_lead(h_lead),
    .v_lead(v_lead),
    .pix   (pix),
    .line  (line)
  );

  dlc_window #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W),
    .ACT_W (ACT_W),
    .ACT_H (ACT_H),
    .ADDR_W(ADDR_W)
  ) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix        (pix),
    .line       (line),
    .v_lead     (v_lead),
    .code       (code_al),
    .h_start    (h_start),
    .v_start    (v_start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_start(frame_start)
  );

  p_fs_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  p_quiet_reset_r8: assert property (@(posedge clk)
    !rst_n |=> (!wr_en && !frame_start));

endmodule

// File: tb/dotline_capture_tb.sv
module dotline_capture_tb;

  localparam int PIX_W  = 6;
  localparam int LINE_W = 4;
  localparam int ACT_W  = 8;
  localparam int ACT_H  = 4;
  localparam int ADDR_W = 5;
  localparam int NWORDS = ACT_W * ACT_H;
  localparam int H_TOT  = 40;
  localparam int HSW    = 4;
  localparam int V_TOT  = 12;
  localparam int VSW    = 2;
  localparam int PMAX   = (1 << PIX_W) - 1;
  localparam int LMAX   = (1 << LINE_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, dot_in = 1'b0, bright_in = 1'b0;
  logic [PIX_W-1:0]  h_start = '0;
  logic [LINE_W-1:0] v_start = '0;
  logic              wr_en, frame_start;
  logic [ADDR_W-1:0] wr_addr;
  logic [1:0]        wr_data;

  always #2 clk = ~clk;

  dotline_capture #(
    .PIX_W(PIX_W), .LINE_W(LINE_W), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .SYNC_STAGES(2), .ADDR_W(ADDR_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .dot_in(dot_in), .bright_in(bright_in), .h_start(h_start),
    .v_start(v_start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(frame_start)
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Captured side
  logic [1:0] got_mem [NWORDS];
  int         got_cnt, got_fs, got_bad;

  // Expected side: per-sample model of the requirements
  logic [1:0] exp_mem [NWORDS];
  int         exp_cnt, exp_fs;
  int         m_pix = PMAX, m_line = LMAX, m_hs = 0, m_vs = 0;
  logic       m_hp = 1'b0, m_vp = 1'b0;

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (int'(wr_addr) < NWORDS) got_mem[wr_addr] = wr_data;
      else got_bad++;
      got_cnt++;
    end
    if (rst_n && frame_start) begin
      got_fs++;
      if (!(wr_en && wr_addr == '0)) got_bad++;
    end
  end

  task automatic clear_logs();
    for (int i = 0; i < NWORDS; i++) begin
      got_mem[i] = 2'bxx;
      exp_mem[i] = 2'bxx;
    end
    got_cnt = 0; got_fs = 0; got_bad = 0;
    exp_cnt = 0; exp_fs = 0;
  endtask

  task automatic drive(input logic h, input logic v, input logic d, input logic b);
    bit hr, vr;
    int rx, ry;
    @(negedge clk);
    hsync_in = h; vsync_in = v; dot_in = d; bright_in = b;
    hr = h && !m_hp;
    vr = v && !m_vp;
    m_hp = h; m_vp = v;
    if (hr) m_pix = 0; else if (m_pix < PMAX) m_pix++;
    if (vr) begin
      m_line = 0; m_hs = int'(h_start); m_vs = int'(v_start);
    end else if (hr && m_line < LMAX) m_line++;
    if (m_pix >= m_hs && m_pix < m_hs + ACT_W &&
        m_line >= m_vs && m_line < m_vs + ACT_H) begin
      rx = m_pix - m_hs;
      ry = m_line - m_vs;
      exp_mem[ry * ACT_W + rx] = {d, b};
      exp_cnt++;
      if (rx == 0 && ry == 0) exp_fs++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // One frame; vertical sync rises at pixel vofs of line 0. If chg_line is
  // non-negative, the offsets are rewritten partway through that line.
  task automatic frame(input int seed, input int vofs, input int chg_line,
                       input int nh, input int nv);
    logic v, d, b;
    for (int l = 0; l < V_TOT; l++) begin
      for (int p = 0; p < H_TOT; p++) begin
        v = (l == 0) ? (p >= vofs) : (l < VSW);
        d = (((l * 7 + p * 3 + seed) % 5) != 0);
        b = (((l + p * 2 + seed) % 3) == 0);
        if (l == chg_line && p == 20) begin
          h_start = PIX_W'(nh);
          v_start = LINE_W'(nv);
        end
        drive(p < HSW, v, d, b);
      end
    end
    idle(10);
  endtask

  task automatic compare(input string req);
    int mism = 0, first = -1;
    for (int i = 0; i < NWORDS; i++) begin
      if (exp_mem[i] !== 2'bxx && got_mem[i] !== exp_mem[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    chk(got_cnt == exp_cnt && got_bad == 0, req, "write count", got_cnt, exp_cnt);
    chk(got_fs == exp_fs, req, "frame_start count", got_fs, exp_fs);
    chk(mism == 0, req, "buffer words mismatching (first index shown as expected)",
        mism, first);
  endtask

  task automatic t_reset();
    clear_logs();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(!wr_en && !frame_start, "R8", "outputs in reset",
        int'({wr_en, frame_start}), 0);
    rst_n = 1'b1;
    idle(40);
    chk(got_cnt == 0, "R8", "writes before any sync", got_cnt, 0);
    chk(got_fs == 0, "R8", "frame pulses before any sync", got_fs, 0);
  endtask

  // R1 R3 R4 R5 R7: syncs rise together, long horizontal pulse
  task automatic t_basic();
    clear_logs();
    h_start = 6; v_start = 2;
    frame(1, 0, -1, 0, 0);
    compare("R1/R3/R4/R5/R7 basic");
  endtask

  // R3 R4: window pushed to the far edges
  task automatic t_far_window();
    clear_logs();
    h_start = 24; v_start = 8;
    frame(4, 0, -1, 0, 0);
    compare("R3/R4 far window");
  endtask

  // R6: mid-frame offset rewrite takes effect only at the next vsync
  task automatic t_midframe();
    clear_logs();
    h_start = 10; v_start = 3;
    frame(2, 0, 1, 0, 0);
    chk(exp_fs == 1, "R6", "model origin at old offsets", exp_fs, 1);
    compare("R6 old offsets held");
    clear_logs();
    frame(3, 0, -1, 0, 0);
    compare("R6 new offsets zero");
  endtask

  // R2: vertical sync rising mid-line; origin row partly missed
  task automatic t_vsync_midline();
    clear_logs();
    h_start = 0; v_start = 0;
    frame(5, 3, -1, 0, 0);
    chk(exp_fs == 0 && exp_cnt == NWORDS - 3, "R2", "model count", exp_cnt, NWORDS - 3);
    compare("R2 vsync mid-line");
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    clear_logs();
    t_reset();
    t_basic();
    t_far_window();
    t_midframe();
    t_vsync_midline();
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule